// File: doc/BRIEF.md
# Byte and Word Pointer Memory Access Unit

This unit performs the memory side of load and store operations for a 32-bit processor whose memory bus only moves aligned 32-bit words. It accepts one request at a time, made of an operation code, a pointer value, an index value and store data, runs a single word-wide bus transfer with a valid/ready handshake and per-byte write enables, and then retires the access. On retire it returns the loaded value and the updated pointer for write-back.

Bytes sit big-endian inside each word: the byte at offset 0 of a word is its most significant byte. A byte load selects the addressed byte out of the returned word and zero-extends it. A byte store places the byte on its lane and enables only that lane. Byte accesses post-increment the pointer by one. Word accesses support a stack pop form (load, pointer +4) and a stack push form (store, pointer -4). Plain and indexed forms leave the pointer alone; the indexed forms address pointer plus index.

Top module: `byte_lsu`

## Requirements
- R1: `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high; after reset `req_ready` is 1 while `bus_valid`, `done`, `ld_we` and `ptr_we` are 0.
- R2: From the cycle after a request is taken, `bus_valid` stays high with `bus_addr`, `bus_we`, `bus_be` and `bus_wdata` unchanged until the edge where `bus_ready` is high; request inputs that change in that time have no effect on the bus or the results.
- R3: `done` is high for exactly one cycle per access, the cycle right after the bus handshake edge.
- R4: `bus_addr` is the effective address with its two low bits forced to 0; the effective address is `req_ptr + req_idx` for op codes 6 (indexed load) and 7 (indexed store), and `req_ptr` for all others.
- R5: Op 4 (byte load, post-increment) returns on `ld_data` the byte at bit position (3 - a[1:0]) x 8 of `bus_rdata`, where a is the effective address, zero-extended to 32 bits.
- R6: Op 5 (byte store, post-increment) drives `bus_we`=1, `bus_be` with only bit (3 - a[1:0]) set, and `bus_wdata` holding `req_wdata[7:0]` at bits (3 - a[1:0]) x 8 upward with all other bits 0.
- R7: Word stores (ops 1, 3, 7) drive `bus_we`=1, `bus_be`=4'b1111 and `bus_wdata`=`req_wdata`; loads (ops 0, 2, 4, 6) drive `bus_we`=0 and `bus_be`=0, and word loads (ops 0, 2, 6) return `bus_rdata` unchanged.
- R8: Ops 4 and 5 return `req_ptr + 1`, op 2 returns `req_ptr + 4` and op 3 returns `req_ptr - 4` on `ptr_data`, with `ptr_we` high in the `done` cycle, wrapping modulo 2^32.
- R9: Ops 0, 1, 6 and 7 never raise `ptr_we`; `ld_we` is high in the `done` cycle of every load and never for a store; neither write strobe is high outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Operation code (0 LDW, 1 STW, 2 LDW+4, 3 STW-4, 4 LDB+1, 5 STB+1, 6 LD indexed, 7 ST indexed) |
| req_ptr | input | 32 | Pointer register value |
| req_idx | input | 32 | Index register value for indexed forms |
| req_wdata | input | 32 | Store data |
| bus_valid | output | 1 | Bus transfer requested |
| bus_ready | input | 1 | Bus accepts the transfer (and read data is valid) |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_we | output | 1 | Write transfer |
| bus_be | output | 4 | Byte write enables, bit 3 = most significant byte |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled at the handshake edge |
| done | output | 1 | Access retires this cycle |
| ld_data | output | 32 | Loaded value for write-back |
| ld_we | output | 1 | Write back `ld_data` |
| ptr_data | output | 32 | Updated pointer value |
| ptr_we | output | 1 | Write back `ptr_data` |

## Verification
The checker watches every cycle for the handshake rules: the bus request holding steady until accepted, `done` following each bus handshake as a single-cycle pulse, `req_ready` excluding an active bus, aligned addresses, legal enable patterns for reads and writes, and write strobes confined to the `done` cycle. What those properties cannot see is the data arithmetic: which byte lane a given offset selects, the zero extension, the pointer steps and their wrap, and the indexed address sum. The bench shows these by driving every op code at each byte offset, with varied bus stall lengths, and comparing against values worked out by hand.

// File: rtl/byte_lsu_pkg.sv
package byte_lsu_pkg;

  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_STW  = 3'd1,
    OP_LDWI = 3'd2,
    OP_STWD = 3'd3,
    OP_LDBI = 3'd4,
    OP_STBI = 3'd5,
    OP_LDX  = 3'd6,
    OP_STX  = 3'd7
  } lsu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RET  = 2'd2
  } lsu_state_e;

  function automatic logic op_is_store(lsu_op_e op);
    return op[0];
  endfunction

  function automatic logic op_is_byte(lsu_op_e op);
    return (op == OP_LDBI) || (op == OP_STBI);
  endfunction

  function automatic logic op_is_indexed(lsu_op_e op);
    return (op == OP_LDX) || (op == OP_STX);
  endfunction

  function automatic logic op_moves_ptr(lsu_op_e op);
    return (op == OP_LDWI) || (op == OP_STWD) || op_is_byte(op);
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import byte_lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  lsu_op_e            op,
  input  logic [AW-1:0]      ptr,
  input  logic [AW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  output logic [AW-1:0]      word_addr,
  output logic [$clog2(DW/8)-1:0] byte_off,
  output logic [DW/8-1:0]    be,
  output logic [DW-1:0]      lane_wdata,
  output logic [AW-1:0]      ptr_next,
  output logic               ptr_upd,
  output logic               is_store
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  // Big-endian lane: offset 0 is the top byte.
  function automatic int lane_of(logic [OFF_W-1:0] off);
    return LANES - 1 - int'(off);
  endfunction

  function automatic logic [DW-1:0] place_byte(logic [7:0] b, logic [OFF_W-1:0] off);
    logic [DW-1:0] wide;
    wide = {{(DW-8){1'b0}}, b};
    return wide << (8 * lane_of(off));
  endfunction

  function automatic logic [LANES-1:0] lane_mask(logic [OFF_W-1:0] off);
    logic [LANES-1:0] one;
    one = {{(LANES-1){1'b0}}, 1'b1};
    return one << lane_of(off);
  endfunction

  logic [AW-1:0] eff_addr;

  always_comb begin
    eff_addr  = op_is_indexed(op) ? (ptr + idx) : ptr;
    byte_off  = eff_addr[OFF_W-1:0];
    word_addr = {eff_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
    is_store  = op_is_store(op);

    if (!is_store)           be = '0;
    else if (op_is_byte(op)) be = lane_mask(byte_off);
    else                     be = '1;

    lane_wdata = op_is_byte(op) ? place_byte(wdata[7:0], byte_off) : wdata;

    ptr_upd = op_moves_ptr(op);
    unique case (op)
      OP_LDBI, OP_STBI: ptr_next = ptr + AW'(1);
      OP_LDWI:          ptr_next = ptr + AW'(LANES);
      OP_STWD:          ptr_next = ptr - AW'(LANES);
      default:          ptr_next = ptr;
    endcase
  end

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import byte_lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  lsu_op_e                  op,
  input  logic [$clog2(DW/8)-1:0]  byte_off,
  input  logic [DW-1:0]            rdata,
  output logic [DW-1:0]            value
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  function automatic logic [7:0] pick_byte(logic [DW-1:0] word, logic [OFF_W-1:0] off);
    logic [DW-1:0] shifted;
    shifted = word >> (8 * (LANES - 1 - int'(off)));
    return shifted[7:0];
  endfunction

  always_comb begin
    if (op_is_byte(op)) value = {{(DW-8){1'b0}}, pick_byte(rdata, byte_off)};
    else                value = rdata;
  end

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import byte_lsu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic bus_ready,
  output logic req_ready,
  output logic bus_active,
  output logic accept,
  output logic bus_fire,
  output logic retire
);
  lsu_state_e state, state_nx;

  assign req_ready  = (state == ST_IDLE);
  assign bus_active = (state == ST_BUS);
  assign retire     = (state == ST_RET);
  assign accept     = req_ready && req_valid;
  assign bus_fire   = bus_active && bus_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept)   state_nx = ST_BUS;
      ST_BUS:  if (bus_fire) state_nx = ST_RET;
      ST_RET:                state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/byte_lsu.sv
module byte_lsu
  import byte_lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_ptr,
  input  logic [AW-1:0]    req_idx,
  input  logic [DW-1:0]    req_wdata,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_we,
  output logic [LANES-1:0] bus_be,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic             done,
  output logic [DW-1:0]    ld_data,
  output logic             ld_we,
  output logic [AW-1:0]    ptr_data,
  output logic             ptr_we
);
  // Named internal events
  logic accept, bus_fire, retire, bus_active;

  // Request decode (combinational, from the request inputs)
  lsu_op_e          in_op;
  logic [AW-1:0]    g_addr;
  logic [OFF_W-1:0] g_off;
  logic [LANES-1:0] g_be;
  logic [DW-1:0]    g_wdata;
  logic [AW-1:0]    g_ptr;
  logic             g_upd;
  logic             g_store;

  // Latched request
  lsu_op_e          r_op;
  logic [AW-1:0]    r_addr;
  logic [OFF_W-1:0] r_off;
  logic [LANES-1:0] r_be;
  logic [DW-1:0]    r_wdata;
  logic [AW-1:0]    r_ptr;
  logic             r_upd;
  logic             r_store;

  logic [DW-1:0]    fmt_value;
  logic [DW-1:0]    r_ld;

  assign in_op = lsu_op_e'(req_op);

  lsu_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .bus_ready  (bus_ready),
    .req_ready  (req_ready),
    .bus_active (bus_active),
    .accept     (accept),
    .bus_fire   (bus_fire),
    .retire     (retire)
  );

  lsu_addr_gen #(.AW(AW), .DW(DW)) u_agen (
    .op         (in_op),
    .ptr        (req_ptr),
    .idx        (req_idx),
    .wdata      (req_wdata),
    .word_addr  (g_addr),
    .byte_off   (g_off),
    .be         (g_be),
    .lane_wdata (g_wdata),
    .ptr_next   (g_ptr),
    .ptr_upd    (g_upd),
    .is_store   (g_store)
  );

  lsu_load_fmt #(.DW(DW)) u_fmt (
    .op       (r_op),
    .byte_off (r_off),
    .rdata    (bus_rdata),
    .value    (fmt_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_op    <= OP_LDW;
      r_addr  <= '0;
      r_off   <= '0;
      r_be    <= '0;
      r_wdata <= '0;
      r_ptr   <= '0;
      r_upd   <= 1'b0;
      r_store <= 1'b0;
    end else if (accept) begin
      r_op    <= in_op;
      r_addr  <= g_addr;
      r_off   <= g_off;
      r_be    <= g_be;
      r_wdata <= g_wdata;
      r_ptr   <= g_ptr;
      r_upd   <= g_upd;
      r_store <= g_store;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        r_ld <= '0;
    else if (bus_fire) r_ld <= fmt_value;
  end

  assign bus_valid = bus_active;
  assign bus_addr  = r_addr;
  assign bus_we    = r_store;
  assign bus_be    = r_be;
  assign bus_wdata = r_wdata;

  assign done     = retire;
  assign ld_data  = r_ld;
  assign ld_we    = retire && !r_store;
  assign ptr_data = r_ptr;
  assign ptr_we   = retire && r_upd;

endmodule

// File: rtl/byte_lsu_checker.sv
module byte_lsu_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [LANES-1:0] bus_be,
  input logic [DW-1:0]    bus_wdata,
  input logic             done,
  input logic             ld_we,
  input logic             ptr_we
);

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_valid && !done));

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_be) && $stable(bus_wdata)));

  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> done);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[OFF_W-1:0] == '0));

  assert_write_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |-> (($countones(bus_be) == 1) || (&bus_be)));

  assert_read_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |-> (bus_be == '0));

  assert_strobe_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we || ptr_we) |-> done);

endmodule

bind byte_lsu byte_lsu_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .done      (done),
  .ld_we     (ld_we),
  .ptr_we    (ptr_we)
);

// File: tb/byte_lsu_tb_top.sv
module byte_lsu_tb_top;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] ptr;
    logic [31:0] idx;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [31:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic [31:0] e_ld;
    logic        e_ldwe;
    logic [31:0] e_ptr;
    logic        e_ptrwe;
  } vec_t;

  localparam int NV = 13;
  // op, ptr, idx, wdata, rdata, addr, be, bus_wdata, ld, ld_we, ptr, ptr_we
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1000_0006, 32'h0, 32'h0, 32'hA1B2_C3D4, 32'h1000_0004, 4'h0, 32'h0, 32'hA1B2_C3D4, 1'b1, 32'h0, 1'b0},
    '{3'd1, 32'h0000_0200, 32'h0, 32'hDEAD_BEEF, 32'h0, 32'h0000_0200, 4'hF, 32'hDEAD_BEEF, 32'h0, 1'b0, 32'h0, 1'b0},
    '{3'd2, 32'h0000_0300, 32'h0, 32'h0, 32'h1234_5678, 32'h0000_0300, 4'h0, 32'h0, 32'h1234_5678, 1'b1, 32'h0000_0304, 1'b1},
    '{3'd3, 32'h0000_0400, 32'h0, 32'hCAFE_F00D, 32'h0, 32'h0000_0400, 4'hF, 32'hCAFE_F00D, 32'h0, 1'b0, 32'h0000_03FC, 1'b1},
    '{3'd4, 32'h0000_0500, 32'h0, 32'h0, 32'hA1B2_C3D4, 32'h0000_0500, 4'h0, 32'h0, 32'h0000_00A1, 1'b1, 32'h0000_0501, 1'b1},
    '{3'd4, 32'h0000_0503, 32'h0, 32'h0, 32'hA1B2_C3D4, 32'h0000_0500, 4'h0, 32'h0, 32'h0000_00D4, 1'b1, 32'h0000_0504, 1'b1},
    '{3'd4, 32'h0000_0501, 32'h0, 32'h0, 32'hA1B2_C3D4, 32'h0000_0500, 4'h0, 32'h0, 32'h0000_00B2, 1'b1, 32'h0000_0502, 1'b1},
    '{3'd5, 32'h0000_0602, 32'h0, 32'hFFFF_FF5A, 32'h0, 32'h0000_0600, 4'b0010, 32'h0000_5A00, 32'h0, 1'b0, 32'h0000_0603, 1'b1},
    '{3'd5, 32'h0000_0600, 32'h0, 32'h0000_0077, 32'h0, 32'h0000_0600, 4'b1000, 32'h7700_0000, 32'h0, 1'b0, 32'h0000_0601, 1'b1},
    '{3'd6, 32'h0000_1000, 32'h24, 32'h0, 32'h0BAD_F00D, 32'h0000_1024, 4'h0, 32'h0, 32'h0BAD_F00D, 1'b1, 32'h0, 1'b0},
    '{3'd7, 32'h0000_2000, 32'h13, 32'h1122_3344, 32'h0, 32'h0000_2010, 4'hF, 32'h1122_3344, 32'h0, 1'b0, 32'h0, 1'b0},
    '{3'd3, 32'h0000_0000, 32'h0, 32'h0000_0001, 32'h0, 32'h0000_0000, 4'hF, 32'h0000_0001, 32'h0, 1'b0, 32'hFFFF_FFFC, 1'b1},
    '{3'd4, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0102_0304, 32'hFFFF_FFFC, 4'h0, 32'h0, 32'h0000_0004, 1'b1, 32'h0000_0000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_ptr = '0;
  logic [31:0] req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        done;
  logic [31:0] ld_data;
  logic        ld_we;
  logic [31:0] ptr_data;
  logic        ptr_we;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  byte_lsu dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_ptr(req_ptr), .req_idx(req_idx), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .ld_data(ld_data), .ld_we(ld_we),
    .ptr_data(ptr_data), .ptr_we(ptr_we)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int stall, input string tag);
    @(negedge clk);
    req_op = v.op; req_ptr = v.ptr; req_idx = v.idx; req_wdata = v.wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R2: scramble the request inputs while the bus transfer is pending
    req_op = ~v.op; req_ptr = 32'h5555_AAAA; req_idx = 32'h0F0F_0F0F; req_wdata = 32'h3C3C_3C3C;
    check(req_ready == 1'b0, "R1", {tag, " ready while busy"}, 32'(req_ready), 32'd0);
    for (int w = 0; w <= stall; w++) begin
      check(bus_valid == 1'b1, "R2", {tag, " bus_valid held"}, 32'(bus_valid), 32'd1);
      check(bus_addr == v.e_addr, "R4", {tag, " bus_addr"}, bus_addr, v.e_addr);
      check(bus_we == v.op[0], "R7", {tag, " bus_we"}, 32'(bus_we), 32'(v.op[0]));
      check(bus_be == v.e_be, v.op == 3'd5 ? "R6" : "R7", {tag, " bus_be"}, 32'(bus_be), 32'(v.e_be));
      if (v.op[0])
        check(bus_wdata == v.e_wd, v.op == 3'd5 ? "R6" : "R7", {tag, " bus_wdata"}, bus_wdata, v.e_wd);
      check(done == 1'b0, "R3", {tag, " done early"}, 32'(done), 32'd0);
      if (w == stall) begin
        bus_ready = 1'b1;
        bus_rdata = v.rd;
      end
      @(posedge clk);
      @(negedge clk);
    end
    bus_ready = 1'b0;
    bus_rdata = 32'hEEEE_EEEE;
    check(done == 1'b1, "R3", {tag, " done after handshake"}, 32'(done), 32'd1);
    check(bus_valid == 1'b0, "R3", {tag, " bus released"}, 32'(bus_valid), 32'd0);
    check(ld_we == v.e_ldwe, "R9", {tag, " ld_we"}, 32'(ld_we), 32'(v.e_ldwe));
    if (v.e_ldwe)
      check(ld_data == v.e_ld, v.op == 3'd4 ? "R5" : "R7", {tag, " ld_data"}, ld_data, v.e_ld);
    check(ptr_we == v.e_ptrwe, v.e_ptrwe ? "R8" : "R9", {tag, " ptr_we"}, 32'(ptr_we), 32'(v.e_ptrwe));
    if (v.e_ptrwe)
      check(ptr_data == v.e_ptr, "R8", {tag, " ptr_data"}, ptr_data, v.e_ptr);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R3", {tag, " done one cycle"}, 32'(done), 32'd0);
    check(ld_we == 1'b0 && ptr_we == 1'b0, "R9", {tag, " strobes after done"},
          32'({ld_we, ptr_we}), 32'd0);
    check(req_ready == 1'b1, "R1", {tag, " ready after retire"}, 32'(req_ready), 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 32'd1);
    check(bus_valid == 1'b0, "R1", "reset bus_valid", 32'(bus_valid), 32'd0);
    check(done == 1'b0 && ld_we == 1'b0 && ptr_we == 1'b0, "R1", "reset done/strobes",
          32'({done, ld_we, ptr_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: no request means nothing starts
    repeat (3) @(negedge clk);
    check(bus_valid == 1'b0, "R1", "idle without request", 32'(bus_valid), 32'd0);

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i], i % 3, $sformatf("vec%0d", i));

    // Corner: long bus stall on a byte store to offset 3 (lane 0), R6
    run_vec('{3'd5, 32'h0000_0703, 32'h0, 32'h0000_00C3, 32'h0, 32'h0000_0700, 4'b0001,
              32'h0000_00C3, 32'h0, 1'b0, 32'h0000_0704, 1'b1}, 7, "stall_stb");
    // Corner: byte store offset 1 (lane 2), R6
    run_vec('{3'd5, 32'h0000_0801, 32'h0, 32'h0000_0099, 32'h0, 32'h0000_0800, 4'b0100,
              32'h0099_0000, 32'h0, 1'b0, 32'h0000_0802, 1'b1}, 0, "stb_off1");
    // Corner: byte load offset 2 with a high top bit, zero-extension R5
    run_vec('{3'd4, 32'h0000_0902, 32'h0, 32'h0, 32'hFFFF_80FF, 32'h0000_0900, 4'h0,
              32'h0, 32'h0000_0080, 1'b1, 32'h0000_0903, 1'b1}, 1, "ldb_off2");
    // Corner: indexed load with wrap-around sum, R4
    run_vec('{3'd6, 32'hFFFF_FFF0, 32'h0000_0015, 32'h0, 32'h7777_0000, 32'h0000_0004, 4'h0,
              32'h0, 32'h7777_0000, 1'b1, 32'h0, 1'b0}, 2, "ldx_wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule